// File: doc/BRIEF.md
# Addressed Serial Command Frame Decoder

This block turns a recovered serial bit stream, delivered one bit per strobe, into fixed 18-bit command frames. Each frame has two bytes, data first, each preceded by its own parity bit. Consecutive frames are separated by one spacer bit. The block keeps frame alignment with a sliding match on a unique sync frame. When the module-address field of a frame equals this instance's strap address and both parity checks pass, the data byte goes into one of four local registers.

The four registers drive a stimulator's control inputs. One register controls the source side and holds an amplitude, an offset bit and two mode bits. A second register controls the sink side and holds an amplitude, an offset bit and two feedback-select bits. The other two registers hold eight drivers' worth of two-bit site status. Many instances can listen to one shared stream, and each instance is told apart by its address parameter.

Top module: `cmd_frame_decoder`

## Requirements
- R1: After reset, all four registers read zero, `frame_valid` is 0 and `parity_error` is 0.
- R2: Frame bits arrive in this order: data parity, data byte MSB first, address parity, address byte MSB first. The address byte's bits [7:2] are the module address and bits [1:0] the register select (0 source control, 1 sink control, 2 site status low, 3 site status high). An accepted frame writes its data byte to the selected register. At the strobe of the frame's last bit, `frame_valid` pulses for exactly one cycle.
- R3: Exactly one bit after each frame is a spacer, and its value is ignored. The next frame starts with the following bit.
- R4: A frame whose module address differs from parameter `MOD_ADDR` (default 6'h3F) changes no register, gives no `frame_valid` pulse and does not set `parity_error`.
- R5: Parity is even per byte, so the parity bit XOR the eight byte bits is 0. A frame that fails either check writes nothing and gives no `frame_valid`. It sets `parity_error`, whatever its address. `parity_error` stays set until reset.
- R6: Whenever the last 18 received bits are 0,FFh,0,FFh, the sequencer treats the next bit as a spacer, whatever its previous position. A sync frame never writes and never pulses `frame_valid`.
- R7: `src_amp`/`src_ofs`/`drv_mode` are bits [4:0]/[5]/[7:6] of the source register. `snk_amp`/`snk_ofs`/`fb_sel` are the same bits of the sink register.
- R8: Cycles with `rx_stb` low change no state, whatever `rx_bit` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Recovered serial data |
| rx_stb | input | 1 | One-cycle strobe marking a valid bit |
| ctl_src | output | 8 | Source control register |
| ctl_snk | output | 8 | Sink control register |
| site_lo | output | 8 | Site status, drivers 0-3 |
| site_hi | output | 8 | Site status, drivers 4-7 |
| src_amp | output | 5 | Source amplitude |
| src_ofs | output | 1 | Source offset bit |
| drv_mode | output | 2 | Operating mode bits |
| snk_amp | output | 5 | Sink amplitude |
| snk_ofs | output | 1 | Sink offset bit |
| fb_sel | output | 2 | Feedback select bits |
| frame_valid | output | 1 | One-cycle pulse per accepted frame |
| parity_error | output | 1 | Sticky parity fault flag |

## Verification
On every cycle, the assertions check four things. Register contents change only together with a `frame_valid` pulse. That pulse follows a strobe and lasts one cycle. Idle cycles without a strobe leave everything still. `parity_error` never clears on its own. The directed scenarios are needed for the rest: which register an address selects, discarding for address mismatch and for each parity byte, ignoring the spacer value, and recovery after a bit slip. These depend on the content and alignment of whole frames, which a single-cycle property cannot follow.

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder #(
  parameter logic [5:0] MOD_ADDR = 6'h3F,
  parameter int         BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              rx_stb,
  output logic [BYTE_W-1:0] ctl_src,
  output logic [BYTE_W-1:0] ctl_snk,
  output logic [BYTE_W-1:0] site_lo,
  output logic [BYTE_W-1:0] site_hi,
  output logic [4:0]        src_amp,
  output logic              src_ofs,
  output logic [1:0]        drv_mode,
  output logic [4:0]        snk_amp,
  output logic              snk_ofs,
  output logic [1:0]        fb_sel,
  output logic              frame_valid,
  output logic              parity_error
);
  localparam int FRAME_W = 2 * (BYTE_W + 1);
  localparam int POS_W   = $clog2(FRAME_W + 1);
  localparam logic [POS_W-1:0] SPACER_POS = POS_W'(FRAME_W);
  localparam logic [POS_W-1:0] LAST_POS   = POS_W'(FRAME_W - 1);
  localparam logic [FRAME_W-1:0] SYNC_WORD = {1'b0, {BYTE_W{1'b1}}, 1'b0, {BYTE_W{1'b1}}};

  logic [FRAME_W-1:0] win_q;
  logic [FRAME_W-1:0] win_d;
  logic [POS_W-1:0]   pos_q;
  logic [BYTE_W-1:0]  regs_q [4];

  assign win_d = {win_q[FRAME_W-2:0], rx_bit};

  logic              is_sync, frame_end, par_ok, addr_hit, wr;
  logic [BYTE_W-1:0] dbyte, abyte;
  logic              dpar, apar;

  assign dpar  = win_d[FRAME_W-1];
  assign dbyte = win_d[FRAME_W-2 -: BYTE_W];
  assign apar  = win_d[BYTE_W];
  assign abyte = win_d[BYTE_W-1:0];

  assign is_sync   = (win_d == SYNC_WORD);
  assign frame_end = rx_stb && (pos_q == LAST_POS) && !is_sync;
  assign par_ok    = !(dpar ^ (^dbyte)) && !(apar ^ (^abyte));
  assign addr_hit  = (abyte[BYTE_W-1:2] == MOD_ADDR);
  assign wr        = frame_end && par_ok && addr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q        <= '0;
      pos_q        <= '0;
      frame_valid  <= 1'b0;
      parity_error <= 1'b0;
    end else begin
      frame_valid <= wr;
      if (frame_end && !par_ok) parity_error <= 1'b1;
      if (rx_stb) begin
        win_q <= win_d;
        if (is_sync)                 pos_q <= SPACER_POS;
        else if (pos_q == SPACER_POS) pos_q <= '0;
        else                          pos_q <= pos_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                        regs_q[g] <= '0;
      else if (wr && abyte[1:0] == 2'(g)) regs_q[g] <= dbyte;
    end
  end

  assign ctl_src  = regs_q[0];
  assign ctl_snk  = regs_q[1];
  assign site_lo  = regs_q[2];
  assign site_hi  = regs_q[3];
  assign src_amp  = regs_q[0][4:0];
  assign src_ofs  = regs_q[0][5];
  assign drv_mode = regs_q[0][7:6];
  assign snk_amp  = regs_q[1][4:0];
  assign snk_ofs  = regs_q[1][5];
  assign fb_sel   = regs_q[1][7:6];
endmodule

// File: rtl/cmd_frame_decoder_chk.sv
module cmd_frame_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_stb,
  input logic        frame_valid,
  input logic        parity_error,
  input logic [31:0] regs_flat
);
  // R2
  fv_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(rx_stb));
  // R2
  fv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);
  // R2
  reg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_flat != $past(regs_flat)) |-> frame_valid);
  // R8
  nostb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_stb |=> ($stable(regs_flat) && !frame_valid));
  // R5
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_error |=> parity_error);
endmodule

bind cmd_frame_decoder cmd_frame_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .frame_valid(frame_valid),
  .parity_error(parity_error), .regs_flat({ctl_src, ctl_snk, site_lo, site_hi})
);

// File: tb/tb_cmd_frame_decoder.sv
module tb_cmd_frame_decoder;
  localparam logic [5:0] ADDR = 6'h15;
  logic clk = 1'b0, rst_n = 1'b0, rx_bit = 1'b0, rx_stb = 1'b0;
  logic [7:0] ctl_src, ctl_snk, site_lo, site_hi;
  logic [4:0] src_amp, snk_amp;
  logic src_ofs, snk_ofs, frame_valid, parity_error;
  logic [1:0] drv_mode, fb_sel;
  int total = 0, bad = 0;
  logic [7:0] exp_r [4];
  logic fv_seen;

  always #2 clk = ~clk;

  cmd_frame_decoder #(.MOD_ADDR(ADDR)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk({tag, " ctl_src"}, ctl_src, exp_r[0]);
    chk({tag, " ctl_snk"}, ctl_snk, exp_r[1]);
    chk({tag, " site_lo"}, site_lo, exp_r[2]);
    chk({tag, " site_hi"}, site_hi, exp_r[3]);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_bit = b; rx_stb = 1'b1;
    @(negedge clk); rx_stb = 1'b0;
  endtask

  task automatic send_raw(input logic [17:0] w);
    for (int i = 17; i >= 0; i--) send_bit(w[i]);
    fv_seen = frame_valid;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [7:0] a,
                            input logic dflip, input logic aflip, input logic sp);
    send_raw({(^d) ^ dflip, d, (^a) ^ aflip, a});
    send_bit(sp);
  endtask

  task automatic t_reset();
    chk("R1 frame_valid", frame_valid, 0);
    chk("R1 parity_error", parity_error, 0);
    chk_regs("R1");
  endtask

  task automatic t_writes();
    logic [7:0] vals [4] = '{8'hA5, 8'h3C, 8'h81, 8'h7E};
    for (int s = 0; s < 4; s++) begin
      send_frame(vals[s], {ADDR, 2'(s)}, 0, 0, 0);
      exp_r[s] = vals[s];
      chk("R2 frame_valid pulse", fv_seen, 1);
      chk("R2 frame_valid cleared", frame_valid, 0);
      chk_regs("R2");
    end
    chk("R7 src_amp", src_amp, 5'h05);
    chk("R7 src_ofs", src_ofs, 1);
    chk("R7 drv_mode", drv_mode, 2'b10);
    chk("R7 snk_amp", snk_amp, 5'h1C);
    chk("R7 snk_ofs", snk_ofs, 1);
    chk("R7 fb_sel", fb_sel, 2'b00);
  endtask

  task automatic t_spacer();
    send_frame(8'h12, {ADDR, 2'd0}, 0, 0, 1);
    exp_r[0] = 8'h12;
    send_frame(8'h34, {ADDR, 2'd2}, 0, 0, 1);
    exp_r[2] = 8'h34;
    chk("R3 aligned after one-valued spacer", fv_seen, 1);
    chk_regs("R3");
  endtask

  task automatic t_no_strobe();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); rx_bit = i[0];
    end
    chk_regs("R8 idle");
    send_frame(8'h0F, {ADDR, 2'd1}, 0, 0, 0);
    exp_r[1] = 8'h0F;
    chk("R8 still aligned", fv_seen, 1);
    chk_regs("R8");
  endtask

  task automatic t_mismatch();
    send_frame(8'h55, {6'h16, 2'd0}, 0, 0, 0);
    chk("R4 no pulse", fv_seen, 0);
    chk("R4 no parity flag", parity_error, 0);
    send_frame(8'h55, {6'h3F, 2'd3}, 0, 0, 0);
    chk("R4 no pulse default addr", fv_seen, 0);
    chk_regs("R4");
  endtask

  task automatic t_parity();
    send_frame(8'h99, {ADDR, 2'd0}, 1, 0, 0);
    chk("R5 data parity no pulse", fv_seen, 0);
    chk("R5 flag set", parity_error, 1);
    chk_regs("R5 data");
    send_frame(8'h77, {ADDR, 2'd3}, 0, 1, 0);
    chk("R5 addr parity no pulse", fv_seen, 0);
    chk_regs("R5 addr");
    send_frame(8'h44, {ADDR, 2'd3}, 0, 0, 0);
    exp_r[3] = 8'h44;
    chk("R5 flag sticky", parity_error, 1);
    chk_regs("R5 good after fault");
  endtask

  task automatic t_resync();
    send_bit(1'b0);
    for (int i = 0; i < 20; i++) send_bit(1'b0);
    chk_regs("R6 slipped zeros");
    send_raw({1'b0, 8'hFF, 1'b0, 8'hFF});
    chk("R6 sync no pulse", fv_seen, 0);
    chk_regs("R6 sync no write");
    send_bit(1'b1);
    send_frame(8'h66, {ADDR, 2'd2}, 0, 0, 0);
    exp_r[2] = 8'h66;
    chk("R6 realigned pulse", fv_seen, 1);
    chk_regs("R6 realigned");
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_r[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_writes();
    t_spacer();
    t_no_strobe();
    t_mismatch();
    t_parity();
    t_resync();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule